// File: doc/BRIEF.md
# Decimal-Modulus Pulse Divider

This block divides its clock by a three-digit decimal modulus N. It emits a one-clock pulse on `pulse_o` once every N clocks. The modulus arrives as a ten-bit word of binary-coded decimal digits, and N may be any value from 1 to 399. Inside, the count is a chain of decimal digit counters that count down and borrow from one digit to the next, so the modulus word loads without a conversion to binary. When the count reaches one, the counter reloads from the word present on `mod_i` at that clock edge and raises the pulse.

All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. A word whose tens or units digit is above nine is flagged on `bad_mod_o` while it is applied, and the divider treats it as divide-by-1. The all-zero word is also treated as divide-by-1.

Top module: `bcd_freq_div`

## Requirements
- R1: `mod_i` bits [9:8] hold the hundreds digit (0 to 3), bits [7:4] the tens digit and bits [3:0] the units digit, all in BCD. For a valid non-zero word, N = 100·hundreds + 10·tens + units, and successive `pulse_o` pulses are exactly N clocks apart.
- R2: For N of 2 or more, `pulse_o` is high for exactly one clock per count cycle and low in every other clock.
- R3: Word 10'h245 (10 0100 0101) gives pulses 245 clocks apart. Word 10'h146 (01 0100 0110) gives pulses 146 clocks apart.
- R4: The largest word, 10'h399 (hundreds 3, tens 9, units 9), gives pulses 399 clocks apart.
- R5: The all-zero word acts as divide-by-1 and does not raise `bad_mod_o`.
- R6: `bad_mod_o` is high, combinationally in the same cycle, exactly while the tens or units digit of `mod_i` is above 9. Such a word acts as divide-by-1.
- R7: In divide-by-1, `pulse_o` is high on every clock.
- R8: `mod_i` is sampled only at the reload edge. A change made part-way through a count cycle does not alter that cycle's length, and the new N applies from the next cycle on. A change applied just before the reload edge is taken at that edge.
- R9: Synchronous reset clears `pulse_o` and loads N from the current `mod_i`. The first pulse appears after the Nth rising edge that follows the last edge with `rst_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| mod_i | input | 10 | BCD modulus word: hundreds [9:8], tens [7:4], units [3:0] |
| pulse_o | output | 1 | One-clock pulse at each reload |
| bad_mod_o | output | 1 | High while `mod_i` holds a digit above 9 |

## Verification
Two things can happen in the same clock: a change of the modulus word and the reload that samples it. The bench provokes this in two ways. In one case it changes `mod_i` a few clocks into a cycle. In the other it changes `mod_i` on the falling edge just before the reload edge. A monitor counts the clocks between pulses and compares each gap against a queue of expected gaps. The gap of the cycle already in progress must keep the old N, and the next gap must show the new N. The bench also asserts reset partway through a cycle, then judges the first gap after release against the freshly applied word.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
  localparam int DIG_W   = 4;
  localparam int DEC_TOP = 9;

  typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/bcd_mod_decode.sv
module bcd_mod_decode
  import bcd_div_pkg::*;
#(
  parameter int NDIG  = 3,
  parameter int TOP_W = 2
) (
  input  logic [TOP_W+(NDIG-1)*DIG_W-1:0] mod_i,
  output logic [NDIG*DIG_W-1:0]           ld_o,
  output logic                            bad_o
);
  localparam int MOD_W = TOP_W + (NDIG - 1) * DIG_W;
  localparam int CNT_W = NDIG * DIG_W;

  logic [CNT_W-1:0] raw;
  logic [NDIG-1:0]  over;
  logic             is_zero;

  genvar g;
  generate
    for (g = 0; g < NDIG - 1; g++) begin : g_low
      assign raw[g*DIG_W +: DIG_W] = mod_i[g*DIG_W +: DIG_W];
    end
  endgenerate

  // Leading digit is narrower; widen it to a full digit.
  assign raw[CNT_W-1 -: DIG_W] = digit_t'(mod_i[MOD_W-1 -: TOP_W]);

  generate
    for (g = 0; g < NDIG; g++) begin : g_range
      assign over[g] = raw[g*DIG_W +: DIG_W] > digit_t'(DEC_TOP);
    end
  endgenerate

  assign bad_o   = |over;
  assign is_zero = (raw == '0);

  // Zero and illegal words both fall back to a count of one.
  assign ld_o = (bad_o || is_zero) ? {{(CNT_W-1){1'b0}}, 1'b1} : raw;
endmodule

// File: rtl/bcd_digit_cnt.sv
module bcd_digit_cnt
  import bcd_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   load_i,
  input  digit_t load_val_i,
  input  logic   dec_i,
  output digit_t q_o,
  output logic   zero_o
);
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      q_o <= load_val_i;
    end else if (dec_i) begin
      q_o <= (q_o == '0) ? digit_t'(DEC_TOP) : q_o - digit_t'(1);
    end
  end

  assign zero_o = (q_o == '0);
endmodule

// File: rtl/bcd_freq_div.sv
module bcd_freq_div
  import bcd_div_pkg::*;
#(
  parameter int NDIG  = 3,
  parameter int TOP_W = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [TOP_W+(NDIG-1)*DIG_W-1:0] mod_i,
  output logic                            pulse_o,
  output logic                            bad_mod_o
);
  localparam int CNT_W = NDIG * DIG_W;

  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] cnt_q;
  logic [NDIG-1:0]  dig_zero;
  logic [NDIG-1:0]  dig_dec;
  logic             tc;
  logic             reload;
  logic             pulse_q;

  bcd_mod_decode #(
    .NDIG  (NDIG),
    .TOP_W (TOP_W)
  ) u_decode (
    .mod_i (mod_i),
    .ld_o  (ld_val),
    .bad_o (bad_mod_o)
  );

  assign reload     = rst_i | tc;
  assign dig_dec[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_dig
      if (g > 0) begin : g_borrow
        // A digit steps only when every lower digit wraps this clock.
        assign dig_dec[g] = dig_dec[g-1] & dig_zero[g-1];
      end
      bcd_digit_cnt u_cnt (
        .clk_i      (clk_i),
        .load_i     (reload),
        .load_val_i (ld_val[g*DIG_W +: DIG_W]),
        .dec_i      (dig_dec[g]),
        .q_o        (cnt_q[g*DIG_W +: DIG_W]),
        .zero_o     (dig_zero[g])
      );
    end
  endgenerate

  // Terminal count: value 1, i.e. units one and every upper digit zero.
  assign tc = (cnt_q[DIG_W-1:0] == digit_t'(1)) && (&dig_zero[NDIG-1:1]);

  always_ff @(posedge clk_i) begin
    if (rst_i) pulse_q <= 1'b0;
    else       pulse_q <= tc;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/bcd_freq_div_chk.sv
module bcd_freq_div_chk
  import bcd_div_pkg::*;
#(
  parameter int NDIG  = 3,
  parameter int TOP_W = 2
) (
  input logic                            clk_i,
  input logic                            rst_i,
  input logic [TOP_W+(NDIG-1)*DIG_W-1:0] mod_i,
  input logic                            pulse_o,
  input logic                            bad_mod_o,
  input logic                            tc_i,
  input logic [NDIG*DIG_W-1:0]           cnt_i
);
  function automatic logic digits_ok(logic [NDIG*DIG_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (v[i*DIG_W +: DIG_W] > digit_t'(DEC_TOP)) ok = 1'b0;
    end
    return ok;
  endfunction

  // R2: a pulse follows every terminal count
  p_pulse_on_tc_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_i |=> pulse_o);

  // R2: no pulse without a terminal count
  p_quiet_mid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !tc_i |=> !pulse_o);

  // R9: reset clears the pulse
  p_reset_clear_r9: assert property (@(posedge clk_i)
    rst_i |=> !pulse_o);

  // R5: zero word reloads a count of one
  p_zero_div1_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (tc_i && mod_i == '0) |=> (pulse_o && tc_i));

  // R6: illegal word reloads a count of one
  p_bad_div1_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (tc_i && bad_mod_o) |=> (pulse_o && tc_i));

  // R1: counter digits stay decimal
  p_digits_dec_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    digits_ok(cnt_i));
endmodule

bind bcd_freq_div bcd_freq_div_chk #(
  .NDIG  (NDIG),
  .TOP_W (TOP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .mod_i     (mod_i),
  .pulse_o   (pulse_o),
  .bad_mod_o (bad_mod_o),
  .tc_i      (tc),
  .cnt_i     (cnt_q)
);

// File: tb/bcd_freq_div_tb_top.sv
`timescale 1ns/1ps
module bcd_freq_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic [9:0] mod_i = 10'h001;
  logic       pulse_o;
  logic       bad_mod_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  int    cur_n = 1;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_freq_div dut_i (
    .clk_i     (clk),
    .rst_i     (rst_i),
    .mod_i     (mod_i),
    .pulse_o   (pulse_o),
    .bad_mod_o (bad_mod_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_gap(int n, string req);
    exp_q.push_back(n);
    tag_q.push_back(req);
  endtask

  task automatic wait_pulses(int k);
    repeat (k) begin
      do begin
        @(posedge clk);
        #1;
      end while (!pulse_o);
    end
  endtask

  // Driver: change the word right after a pulse; the running cycle keeps cur_n.
  task automatic step(logic [9:0] word, int n, int k, bit exp_flag, string req);
    @(negedge clk);
    mod_i = word;
    #1;
    check(bad_mod_o == exp_flag, "R6", "error flag", int'(bad_mod_o), int'(exp_flag));
    expect_gap(cur_n, "R1");
    for (int i = 1; i < k; i++) expect_gap(n, req);
    wait_pulses(k);
    cur_n = n;
  endtask

  // Driver: change the word after `delay` falling edges of the running cycle.
  task automatic mid(logic [9:0] word, int n, int delay, string req);
    repeat (delay) @(negedge clk);
    mod_i = word;
    expect_gap(cur_n, req);
    expect_gap(n, req);
    wait_pulses(2);
    cur_n = n;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: count clocks between pulses and compare with the queue.
  initial begin
    int since;
    since = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rst_i) begin
        since = 0;
        check(pulse_o == 1'b0, "R9", "pulse during reset", int'(pulse_o), 0);
      end else begin
        since++;
        if (pulse_o) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected pulse, gap", since, 0);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(since == e, t, "clocks between pulses", since, e);
          end
          since = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WD", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_i = 1'b0;
    cur_n = 1;
    expect_gap(1, "R9");
    wait_pulses(1);

    step(10'h001, 1, 5, 1'b0, "R7");
    step(10'h002, 2, 4, 1'b0, "R2");
    step(10'h010, 10, 3, 1'b0, "R1");
    step(10'h146, 146, 2, 1'b0, "R3");
    step(10'h245, 245, 2, 1'b0, "R3");
    step(10'h399, 399, 2, 1'b0, "R4");
    step(10'h000, 1, 3, 1'b0, "R5");
    step(10'h0A0, 1, 3, 1'b1, "R6");
    step(10'h00C, 1, 2, 1'b1, "R6");
    step(10'h010, 10, 2, 1'b0, "R1");

    // R8: change four clocks into a cycle of ten
    mid(10'h007, 7, 4, "R8");
    // R8: change on the falling edge just before the reload edge
    mid(10'h012, 12, 7, "R8");

    // R9: reset during a run, new word taken at reset
    @(negedge clk);
    rst_i = 1'b1;
    mod_i = 10'h005;
    @(negedge clk);
    rst_i = 1'b0;
    repeat (3) expect_gap(5, "R9");
    wait_pulses(3);

    check(exp_q.size() == 0, "R1", "expected gaps left over", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule